// File: doc/BRIEF.md
# Digital PAL Chroma Phase Generator

This block produces PAL colour information for a test pattern source in which every primary is either fully on or fully off. Such a source never needs an analogue modulator. A saturated colour is a fixed vector, so its chroma is a fixed set of square-wave subcarrier phases that is switched on or off. The block runs from a clock at four times the colour subcarrier and divides that clock internally into quarter-cycle phase steps. For each of red, green and blue it forms two gated square waves: one on the U axis and one on the V axis. The V wave reverses sign on alternate lines.

A video timing generator supplies line-start, field-start, burst-window and vertical-sync-line strobes. The block keeps the PAL line-alternation flag from these strobes. It also emits two burst phase lines that, summed, give the swinging burst at ±135° from U. All outputs are registered. An external resistor network weights and sums them into composite video. When all three primaries are on for a white pixel, the six chroma lines run together and their weighted sum cancels.

Top module: `pal_chroma_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the phase divider and `ident_o` clear to 0, and every output reads 0 after that edge.
- R2: Out of reset, the internal phase counter advances by one on each clock and wraps modulo the division ratio (0,1,2,3,0,... for the default ratio of 4). The first edge after reset uses phase 0.
- R3: A square wave of quarter index k is high when (phase − k) mod 4 is 0 or 1. Index 0 is +U, 1 is +V, 2 is −U and 3 is −V.
- R4: Each chroma line is high only if its primary enable was high at the previous rising edge. Otherwise it is 0.
- R5: Red uses U index 2. Its V index is 1 while the ident flag is 0 and 3 while it is 1.
- R6: Green uses U index 2. Its V index is 3 while the ident flag is 0 and 1 while it is 1.
- R7: Blue uses U index 0. Its V index is 3 while the ident flag is 0 and 1 while it is 1.
- R8: `chroma_o` bit order: [0] red U, [1] red V, [2] green U, [3] green V, [4] blue U, [5] blue V. Each output takes the inputs, phase and ident flag held before an edge, and appears after that edge.
- R9: `red_o`, `grn_o` and `blu_o` equal their enables delayed by one clock.
- R10: A `line_start_i` pulse without `field_start_i` inverts `ident_o` at that edge. With neither strobe, `ident_o` holds.
- R11: `field_start_i` forces `ident_o` to 0 at that edge and overrides a simultaneous line start.
- R12: When `burst_win_i` is high and `vsync_line_i` is low, `burst_u_o` follows index 2 and `burst_v_o` follows index 1 (ident 0) or index 3 (ident 1). Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at four times subcarrier |
| rst_i | input | 1 | Synchronous reset, active high |
| field_start_i | input | 1 | Field start strobe, clears the ident flag |
| line_start_i | input | 1 | Line start strobe, toggles the ident flag |
| burst_win_i | input | 1 | Burst window |
| vsync_line_i | input | 1 | High on vertical sync lines, masks burst |
| red_en_i | input | 1 | Red primary active for this pixel |
| grn_en_i | input | 1 | Green primary active for this pixel |
| blu_en_i | input | 1 | Blue primary active for this pixel |
| red_o | output | 1 | Registered red level |
| grn_o | output | 1 | Registered green level |
| blu_o | output | 1 | Registered blue level |
| chroma_o | output | 6 | Gated chroma phase lines, order in R8 |
| burst_u_o | output | 1 | Burst −U component |
| burst_v_o | output | 1 | Burst ±V component |
| ident_o | output | 1 | Line alternation flag |

## Verification
Every colour, chroma and burst output is due one clock after the edge that samples its enable, strobe and phase. The ident flag changes at the same edge that samples a line or field strobe, but it only steers the waves computed from the following edge onward. The bench model advances its own phase and flag at each rising edge. At that edge it stores the outputs it expects, using the flag value from before the update. It compares them at the next falling edge, so each check lands exactly one register stage after its cause.

// File: rtl/pal_chroma_pkg.sv
package pal_chroma_pkg;

   localparam int NUM_PRIM = 3;

   // quarter-cycle indices: 0 = +U, 1 = +V, 2 = -U, 3 = -V
   function automatic int prim_u_quad(input int idx);
      case (idx)
         0: return 2;
         1: return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int prim_v_quad(input int idx);
      case (idx)
         0: return 1;
         default: return 3;
      endcase
   endfunction

   // square wave high for the first half cycle after quarter offset
   function automatic logic sq_wave(input int ph, input int div, input int quad);
      int off;
      off = (ph - quad * (div / 4) + div) % div;
      return off < (div / 2);
   endfunction

   function automatic int flip_quad(input int quad, input logic flip);
      return flip ? ((quad + 2) % 4) : quad;
   endfunction

endpackage

// File: rtl/pcg_phase_div.sv
module pcg_phase_div #(
   parameter int DIV  = 4,
   parameter int PH_W = $clog2(DIV)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   output logic [PH_W-1:0] ph_o
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         ph_o <= '0;
      else if (ph_o == PH_LAST)
         ph_o <= '0;
      else
         ph_o <= ph_o + 1'b1;
   end

   assert_div_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_o != PH_LAST) |=> (ph_o == $past(ph_o) + 1'b1));

   assert_div_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_o == PH_LAST) |=> (ph_o == '0));

endmodule

// File: rtl/pcg_ident.sv
module pcg_ident #(
   parameter bit IDENT_INIT = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic field_start_i,
   input  logic line_start_i,
   output logic ident_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         ident_o <= 1'b0;
      else if (field_start_i)
         ident_o <= IDENT_INIT;
      else if (line_start_i)
         ident_o <= ~ident_o;
   end

   assert_ident_toggle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (line_start_i && !field_start_i) |=> (ident_o != $past(ident_o)));

   assert_ident_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!line_start_i && !field_start_i) |=> $stable(ident_o));

   assert_ident_field_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      field_start_i |=> (ident_o == IDENT_INIT));

endmodule

// File: rtl/pcg_lane.sv
module pcg_lane
   import pal_chroma_pkg::*;
#(
   parameter int DIV  = 4,
   parameter int PH_W = $clog2(DIV),
   parameter int U_Q  = 0,
   parameter int V_Q  = 1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [PH_W-1:0] ph_i,
   input  logic            ident_i,
   input  logic            en_i,
   output logic            u_o,
   output logic            v_o,
   output logic            lvl_o
);

   if (U_Q < 0 || U_Q > 3 || V_Q < 0 || V_Q > 3) begin : g_bad_quad
      $error("pcg_lane: quarter index out of range");
   end

   logic u_wave, v_wave;

   always_comb begin
      u_wave = sq_wave(int'(ph_i), DIV, U_Q);
      v_wave = sq_wave(int'(ph_i), DIV, flip_quad(V_Q, ident_i));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         u_o   <= 1'b0;
         v_o   <= 1'b0;
         lvl_o <= 1'b0;
      end else begin
         u_o   <= en_i & u_wave;
         v_o   <= en_i & v_wave;
         lvl_o <= en_i;
      end
   end

   assert_lane_gate_u_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> !u_o);

   assert_lane_gate_v_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> !v_o);

   assert_lane_level_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> lvl_o);

endmodule

// File: rtl/pcg_burst.sv
module pcg_burst
   import pal_chroma_pkg::*;
#(
   parameter int DIV  = 4,
   parameter int PH_W = $clog2(DIV)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [PH_W-1:0] ph_i,
   input  logic            ident_i,
   input  logic            win_i,
   input  logic            vsync_i,
   output logic            bu_o,
   output logic            bv_o
);

   localparam int BU_Q = 2;
   localparam int BV_Q = 1;

   logic gate;
   logic bu_wave, bv_wave;

   always_comb begin
      gate    = win_i & ~vsync_i;
      bu_wave = sq_wave(int'(ph_i), DIV, BU_Q);
      bv_wave = sq_wave(int'(ph_i), DIV, flip_quad(BV_Q, ident_i));
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         bu_o <= 1'b0;
         bv_o <= 1'b0;
      end else begin
         bu_o <= gate & bu_wave;
         bv_o <= gate & bv_wave;
      end
   end

   assert_burst_mask_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      (!win_i || vsync_i) |=> (!bu_o && !bv_o));

endmodule

// File: rtl/pal_chroma_gen.sv
module pal_chroma_gen
   import pal_chroma_pkg::*;
#(
   parameter int DIV        = 4,
   parameter bit IDENT_INIT = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       field_start_i,
   input  logic       line_start_i,
   input  logic       burst_win_i,
   input  logic       vsync_line_i,
   input  logic       red_en_i,
   input  logic       grn_en_i,
   input  logic       blu_en_i,
   output logic       red_o,
   output logic       grn_o,
   output logic       blu_o,
   output logic [5:0] chroma_o,
   output logic       burst_u_o,
   output logic       burst_v_o,
   output logic       ident_o
);

   localparam int PH_W = $clog2(DIV);

   if (DIV < 4 || (DIV % 4) != 0 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
      $error("pal_chroma_gen: DIV must be a power of two, at least 4");
   end

   logic [PH_W-1:0]     ph;
   logic [NUM_PRIM-1:0] en_vec;
   logic [NUM_PRIM-1:0] lvl_vec;
   logic [NUM_PRIM-1:0] u_vec;
   logic [NUM_PRIM-1:0] v_vec;

   assign en_vec = {blu_en_i, grn_en_i, red_en_i};

   pcg_phase_div #(.DIV(DIV), .PH_W(PH_W)) i_div (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .ph_o  (ph)
   );

   pcg_ident #(.IDENT_INIT(IDENT_INIT)) i_ident (
      .clk_i         (clk_i),
      .rst_i         (rst_i),
      .field_start_i (field_start_i),
      .line_start_i  (line_start_i),
      .ident_o       (ident_o)
   );

   for (genvar gi = 0; gi < NUM_PRIM; gi++) begin : g_lane
      pcg_lane #(
         .DIV  (DIV),
         .PH_W (PH_W),
         .U_Q  (prim_u_quad(gi)),
         .V_Q  (prim_v_quad(gi))
      ) i_lane (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .ph_i    (ph),
         .ident_i (ident_o),
         .en_i    (en_vec[gi]),
         .u_o     (u_vec[gi]),
         .v_o     (v_vec[gi]),
         .lvl_o   (lvl_vec[gi])
      );
      assign chroma_o[2*gi]   = u_vec[gi];
      assign chroma_o[2*gi+1] = v_vec[gi];
   end

   pcg_burst #(.DIV(DIV), .PH_W(PH_W)) i_burst (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ph_i    (ph),
      .ident_i (ident_o),
      .win_i   (burst_win_i),
      .vsync_i (vsync_line_i),
      .bu_o    (burst_u_o),
      .bv_o    (burst_v_o)
   );

   assign red_o = lvl_vec[0];
   assign grn_o = lvl_vec[1];
   assign blu_o = lvl_vec[2];

   assert_reset_clear_R1: assert property (@(posedge clk_i)
      rst_i |=> (chroma_o == '0 && !burst_u_o && !burst_v_o && !ident_o));

   assert_rgb_delay_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      !red_en_i |=> !red_o);

endmodule

// File: tb/test_pal_chroma_gen.sv
module test_pal_chroma_gen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       fs = 1'b0, ls = 1'b0, bw = 1'b0, vs = 1'b0;
   logic       ren = 1'b0, gen = 1'b0, ben = 1'b0;
   logic       red_o, grn_o, blu_o, bu_o, bv_o, id_o;
   logic [5:0] ch_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   pal_chroma_gen i_pal_chroma_gen (
      .clk_i(clk), .rst_i(rst), .field_start_i(fs), .line_start_i(ls),
      .burst_win_i(bw), .vsync_line_i(vs),
      .red_en_i(ren), .grn_en_i(gen), .blu_en_i(ben),
      .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o), .chroma_o(ch_o),
      .burst_u_o(bu_o), .burst_v_o(bv_o), .ident_o(id_o)
   );

   // reference model state
   int   mph = 0;
   logic mid = 1'b0;
   logic       e_rst;
   logic [2:0] e_rgb;
   logic [5:0] e_ch;
   logic       e_bu, e_bv, e_id;
   logic       e_fs;
   bit         armed = 0;
   int         uq[3] = '{2, 2, 0};
   int         vq[3] = '{1, 3, 3};

   function automatic logic wv(input int p, input int k);
      int d;
      d = (p - k + 8) % 4;
      return (d == 0) || (d == 1);
   endfunction

   always @(posedge clk) begin
      logic [2:0] en;
      en = {ben, gen, ren};
      e_rst = rst;
      e_fs  = fs;
      if (rst) begin
         e_rgb = '0; e_ch = '0; e_bu = 0; e_bv = 0;
         mph = 0; mid = 0;
      end else begin
         for (int i = 0; i < 3; i++) begin
            e_rgb[i]     = en[i];
            e_ch[2*i]    = en[i] & wv(mph, uq[i]);
            e_ch[2*i+1]  = en[i] & wv(mph, mid ? (vq[i] + 2) % 4 : vq[i]);
         end
         e_bu = (bw && !vs) & wv(mph, 2);
         e_bv = (bw && !vs) & wv(mph, mid ? 3 : 1);
         mph = (mph + 1) % 4;
         if (fs) mid = 0;
         else if (ls) mid = ~mid;
      end
      e_id  = mid;
      armed = 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (armed && !done) begin
      if (e_rst) begin
         chk("R1 reset outputs", {red_o, grn_o, blu_o, ch_o, bu_o, bv_o, id_o}, 0);
      end else begin
         chk("R9 rgb levels", {blu_o, grn_o, red_o}, e_rgb);
         chk(e_rgb[0] ? "R5 red U/V R2 R3 R8" : "R4 red gated", ch_o[1:0], e_ch[1:0]);
         chk(e_rgb[1] ? "R6 green U/V R2 R3 R8" : "R4 green gated", ch_o[3:2], e_ch[3:2]);
         chk(e_rgb[2] ? "R7 blue U/V R2 R3 R8" : "R4 blue gated", ch_o[5:4], e_ch[5:4]);
         chk("R12 burst", {bu_o, bv_o}, {e_bu, e_bv});
         chk(e_fs ? "R11 ident at field start" : "R10 ident", id_o, e_id);
      end
   end

   // stimulus
   logic [15:0] lfsr = 16'hACE1;

   task automatic step();
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic run_lines(input int nlines, input int mode);
      for (int ln = 0; ln < nlines; ln++) begin
         for (int c = 0; c < 20; c++) begin
            step();
            ls = (c == 0);
            fs = (c == 0) && (ln % 6 == 5);
            vs = (ln % 7 == 3);
            bw = (c >= 2 && c <= 6) || (mode == 5 && lfsr[3]);
            case (mode)
               0: {ben, gen, ren} = 3'b001;
               1: {ben, gen, ren} = 3'b010;
               2: {ben, gen, ren} = 3'b100;
               3: {ben, gen, ren} = 3'b111;
               4: {ben, gen, ren} = 3'b000;
               default: {ben, gen, ren} = lfsr[2:0];
            endcase
            if (mode == 5 && lfsr[9:7] == 3'b101) ls = 1'b1;
            if (mode == 5 && lfsr[11:8] == 4'b0110) fs = 1'b1;
         end
      end
   endtask

   initial begin
      repeat (5) step();
      rst = 1'b0;
      for (int m = 0; m < 6; m++) run_lines(8, m);
      // mid-run reset with strobes and enables active
      step(); rst = 1'b1; {ben, gen, ren} = 3'b111; ls = 1'b1; bw = 1'b1;
      repeat (3) step();
      rst = 1'b0;
      run_lines(40, 5);
      run_lines(4, 3);
      step();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hang expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule